// File: doc/BRIEF.md
# Stack Save/Restore Sequencer

This block takes one decoded multi-register save or restore operation and turns it into a series of single-word stack accesses, one per cycle. The operation names a contiguous span of general registers by an upper and a lower 6-bit index. Three independent flags add the link register, the global pointer and a stack guard word (canary). A direction bit chooses between saving (store) and restoring (load). The block starts from the current stack pointer. It returns the final stack pointer together with a one-cycle done pulse.

Each access is offered on a valid/ready request channel. A request carries a byte address, a slot tag, the register index for span slots, and a write flag. On a save, the slots go out in this fixed order: link register, global pointer, the span in ascending index, then the guard word. A restore walks the same slots in exactly the reverse order. During a restore, the guard word read back from memory is compared with a configured value, and a mismatch raises a fault pulse. Read data is taken from `mem_rdata` in the same cycle that a load request is accepted.

Top module: `multi_xfer_seq`

## Requirements
- R1: `start_ready` is high exactly when the block is idle. A start is taken only when `start_valid` and `start_ready` are both high. While a sequence is in progress, `start_valid` and the operand inputs have no effect on the requests issued.
- R2: On a save, the enabled slots are issued in this order: link register, then global pointer, then the register span, then the guard word. A slot whose flag is clear is skipped.
- R3: The span is issued only when upper >= lower, and then it holds upper-lower+1 requests. On a save they run in ascending index from lower to upper. On a restore they run in descending index from upper to lower. When upper < lower, no span request is issued.
- R4: On a save, each request pre-decrements the stack pointer by 8. The k-th request (k from 1) uses address sp-8k, with `req_write`=1.
- R5: On a restore, the slots come out in the exact reverse of the save order. The k-th request (k from 1) uses address sp+8(k-1), with `req_write`=0.
- R6: When a restore's guard-word request is accepted and `mem_rdata` differs from `canary_cfg`, `canary_fault` is high for exactly the next cycle. All remaining requests are still issued. A matching word raises no fault.
- R7: While `req_valid` is high and `req_ready` is low, `req_addr`, `req_kind`, `req_reg` and `req_write` stay unchanged.
- R8: An operation with no flags set and upper < lower issues no request. It raises `done` in the cycle after the start is taken, and `sp_out` then equals the `sp_in` given at start.
- R9: `done` is a single-cycle pulse. It comes in the cycle after the last request is accepted, and `sp_out` then holds the final stack pointer (sp_in-8n on a save, sp_in+8n on a restore, for n requests).
- R10: The slot tag `req_kind` is encoded as 0 = span register, 1 = link register, 2 = global pointer, 3 = guard word. `req_reg` carries the register index for kind 0 and is 0 for the other kinds.
- R11: After reset, `req_valid`, `done` and `canary_fault` are low and `start_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_valid | input | 1 | New operation offered |
| start_ready | output | 1 | Block idle, operation can be taken |
| span_hi | input | REG_W | Upper register index of the span |
| span_lo | input | REG_W | Lower register index of the span |
| with_link | input | 1 | Include the link register slot |
| with_gp | input | 1 | Include the global pointer slot |
| with_guard | input | 1 | Include the guard word slot |
| is_restore | input | 1 | 1 = restore (loads), 0 = save (stores) |
| sp_in | input | ADDR_W | Stack pointer at start |
| canary_cfg | input | DATA_W | Expected guard word value |
| req_valid | output | 1 | Memory request present |
| req_ready | input | 1 | Memory accepts the request this cycle |
| req_addr | output | ADDR_W | Byte address of the word |
| req_kind | output | 2 | Slot tag (see R10) |
| req_reg | output | REG_W | Register index for span slots |
| req_write | output | 1 | 1 = store, 0 = load |
| mem_rdata | input | DATA_W | Load data, valid with an accepted load request |
| done | output | 1 | Operation complete pulse |
| sp_out | output | ADDR_W | Final stack pointer |
| canary_fault | output | 1 | Guard word mismatch pulse |

## Verification
The hardest case to reach from the ports is a guard-word mismatch in the middle of a restore that is also under backpressure. The fault must fire once, and every later slot must still come out in reverse order at the right address. The bench gets there by driving a mismatching read word while stalling `req_ready` in a repeating pattern. A second hard case is a new start offered while a sequence is running, with very different operands. The bench raises `start_valid` during the busy window and then checks that the request stream matches only the original operation.

// File: rtl/seq_pkg.sv
package seq_pkg;

   typedef enum logic [1:0] {
      SLOT_GPR    = 2'd0,
      SLOT_LINK   = 2'd1,
      SLOT_GP     = 2'd2,
      SLOT_CANARY = 2'd3
   } slot_kind_t;

   localparam int WALK_LEN = 4;

   // Position in the walk -> slot kind; restore walks the save order backwards.
   function automatic slot_kind_t walk_slot(input logic ld, input logic [1:0] p);
      logic [1:0] q;
      q = ld ? (2'd3 - p) : p;
      case (q)
         2'd0:    walk_slot = SLOT_LINK;
         2'd1:    walk_slot = SLOT_GP;
         2'd2:    walk_slot = SLOT_GPR;
         default: walk_slot = SLOT_CANARY;
      endcase
   endfunction

   function automatic logic slot_on(input slot_kind_t k, input logic lnk,
                                    input logic gp, input logic grd, input logic span_ok);
      case (k)
         SLOT_LINK: slot_on = lnk;
         SLOT_GP:   slot_on = gp;
         SLOT_GPR:  slot_on = span_ok;
         default:   slot_on = grd;
      endcase
   endfunction

endpackage

// File: rtl/seq_order_pick.sv
module seq_order_pick #(
   parameter int N = 4,
   localparam int PW = (N > 1) ? $clog2(N) : 1,
   localparam int FW = $clog2(N + 1)
) (
   input  logic [N-1:0]  en,
   input  logic [FW-1:0] from,
   output logic          found,
   output logic [PW-1:0] pos
);
   if (N < 2) begin : g_bad_n
      $error("seq_order_pick needs N >= 2");
   end

   always_comb begin
      found = 1'b0;
      pos   = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (en[i] && (FW'(i) >= from)) begin
            found = 1'b1;
            pos   = PW'(i);
         end
      end
   end
endmodule

// File: rtl/seq_span_walk.sv
module seq_span_walk #(
   parameter int REG_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             init,
   input  logic             dir_in,
   input  logic [REG_W-1:0] lo_in,
   input  logic [REG_W-1:0] hi_in,
   input  logic             step,
   output logic [REG_W-1:0] idx,
   output logic             last
);
   logic [REG_W-1:0] lo_q, hi_q, idx_q;
   logic             dir_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo_q  <= '0;
         hi_q  <= '0;
         idx_q <= '0;
         dir_q <= 1'b0;
      end else if (init) begin
         lo_q  <= lo_in;
         hi_q  <= hi_in;
         dir_q <= dir_in;
         idx_q <= dir_in ? hi_in : lo_in;
      end else if (step) begin
         idx_q <= dir_q ? (idx_q - 1'b1) : (idx_q + 1'b1);
      end
   end

   assign idx  = idx_q;
   assign last = (idx_q == (dir_q ? lo_q : hi_q));

   assert_span_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !init && !last) |=> (dir_q ? (idx == $past(idx) - 1'b1) : (idx == $past(idx) + 1'b1)));
endmodule

// File: rtl/seq_sp_unit.sv
module seq_sp_unit #(
   parameter int ADDR_W     = 64,
   parameter int WORD_BYTES = 8,
   parameter bit GROW_DOWN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load_en,
   input  logic [ADDR_W-1:0] sp_init,
   input  logic              step,
   input  logic              is_load,
   output logic [ADDR_W-1:0] addr,
   output logic [ADDR_W-1:0] sp
);
   localparam logic [ADDR_W-1:0] STEP = ADDR_W'(WORD_BYTES);

   logic [ADDR_W-1:0] sp_q, sp_nxt;

   if (GROW_DOWN) begin : g_down
      assign addr   = is_load ? sp_q : (sp_q - STEP);
      assign sp_nxt = is_load ? (sp_q + STEP) : (sp_q - STEP);
   end else begin : g_up
      assign addr   = is_load ? (sp_q - STEP) : sp_q;
      assign sp_nxt = is_load ? (sp_q - STEP) : (sp_q + STEP);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       sp_q <= '0;
      else if (load_en) sp_q <= sp_init;
      else if (step)    sp_q <= sp_nxt;
   end

   assign sp = sp_q;

   assert_sp_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !load_en) |=> ((sp - $past(sp) == STEP) || ($past(sp) - sp == STEP)));
endmodule

// File: rtl/multi_xfer_seq.sv
module multi_xfer_seq
   import seq_pkg::*;
#(
   parameter int ADDR_W     = 64,
   parameter int DATA_W     = 64,
   parameter int REG_W      = 6,
   parameter int WORD_BYTES = 8,
   parameter bit GROW_DOWN  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_valid,
   output logic              start_ready,
   input  logic [REG_W-1:0]  span_hi,
   input  logic [REG_W-1:0]  span_lo,
   input  logic              with_link,
   input  logic              with_gp,
   input  logic              with_guard,
   input  logic              is_restore,
   input  logic [ADDR_W-1:0] sp_in,
   input  logic [DATA_W-1:0] canary_cfg,
   output logic              req_valid,
   input  logic              req_ready,
   output logic [ADDR_W-1:0] req_addr,
   output logic [1:0]        req_kind,
   output logic [REG_W-1:0]  req_reg,
   output logic              req_write,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              done,
   output logic [ADDR_W-1:0] sp_out,
   output logic              canary_fault
);
   localparam int PW = $clog2(WALK_LEN);
   localparam int FW = $clog2(WALK_LEN + 1);

   if (REG_W < 1 || REG_W > 8) begin : g_bad_reg
      $error("REG_W must be 1..8");
   end
   if (WORD_BYTES < 1 || (WORD_BYTES & (WORD_BYTES - 1)) != 0) begin : g_bad_word
      $error("WORD_BYTES must be a power of two");
   end
   if (ADDR_W < 8) begin : g_bad_addr
      $error("ADDR_W must be at least 8");
   end

   logic                busy_q, ld_q, done_q, fault_q;
   logic [WALK_LEN-1:0] en_q, en_start;
   logic [PW-1:0]       pos_q, pick0_pos, pick1_pos;
   logic                pick0_found, pick1_found;
   logic                accept, hs, span_last, span_more;
   logic [REG_W-1:0]    span_idx;
   logic [ADDR_W-1:0]   addr_w, sp_w;
   slot_kind_t          cur_kind;

   assign accept    = start_valid && !busy_q;
   assign hs        = busy_q && req_ready;
   assign cur_kind  = walk_slot(ld_q, pos_q);
   assign span_more = (cur_kind == SLOT_GPR) && !span_last;

   for (genvar p = 0; p < WALK_LEN; p++) begin : g_en
      assign en_start[p] = slot_on(walk_slot(is_restore, p[1:0]), with_link, with_gp,
                                   with_guard, span_hi >= span_lo);
   end

   seq_order_pick #(.N(WALK_LEN)) u_pick_first (
      .en(en_start), .from(FW'(0)), .found(pick0_found), .pos(pick0_pos));

   seq_order_pick #(.N(WALK_LEN)) u_pick_next (
      .en(en_q), .from(FW'(pos_q) + FW'(1)), .found(pick1_found), .pos(pick1_pos));

   seq_span_walk #(.REG_W(REG_W)) u_span (
      .clk(clk), .rst_n(rst_n), .init(accept), .dir_in(is_restore),
      .lo_in(span_lo), .hi_in(span_hi), .step(hs && cur_kind == SLOT_GPR),
      .idx(span_idx), .last(span_last));

   seq_sp_unit #(.ADDR_W(ADDR_W), .WORD_BYTES(WORD_BYTES), .GROW_DOWN(GROW_DOWN)) u_sp (
      .clk(clk), .rst_n(rst_n), .load_en(accept), .sp_init(sp_in),
      .step(hs), .is_load(ld_q), .addr(addr_w), .sp(sp_w));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         busy_q  <= 1'b0;
         ld_q    <= 1'b0;
         en_q    <= '0;
         pos_q   <= '0;
         done_q  <= 1'b0;
         fault_q <= 1'b0;
      end else begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         if (accept) begin
            ld_q <= is_restore;
            en_q <= en_start;
            if (pick0_found) begin
               busy_q <= 1'b1;
               pos_q  <= pick0_pos;
            end else begin
               done_q <= 1'b1;
            end
         end else if (hs) begin
            if (ld_q && cur_kind == SLOT_CANARY && mem_rdata != canary_cfg)
               fault_q <= 1'b1;
            if (!span_more) begin
               if (pick1_found) begin
                  pos_q <= pick1_pos;
               end else begin
                  busy_q <= 1'b0;
                  done_q <= 1'b1;
               end
            end
         end
      end
   end

   assign start_ready  = !busy_q;
   assign req_valid    = busy_q;
   assign req_write    = !ld_q;
   assign req_kind     = cur_kind;
   assign req_reg      = (cur_kind == SLOT_GPR) ? span_idx : '0;
   assign req_addr     = addr_w;
   assign done         = done_q;
   assign sp_out       = sp_w;
   assign canary_fault = fault_q;

   assert_hold_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !req_ready) |=> (req_valid && $stable(req_addr) && $stable(req_kind)
                                     && $stable(req_reg) && $stable(req_write)));

   assert_busy_ignores_start_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && start_valid) |=> $stable(req_write));

   assert_fault_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
      canary_fault |-> $past(req_valid && req_ready && !req_write && req_kind == 2'd3));

   assert_empty_op_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start_valid && start_ready && !with_link && !with_gp && !with_guard && (span_hi < span_lo))
      |=> (done && !req_valid && sp_out == $past(sp_in)));

   assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!req_valid && !$past(done)));

   assert_tag_reg_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && req_kind != 2'd0) |-> (req_reg == '0));
endmodule

// File: tb/tb_multi_xfer_seq.sv
module tb_multi_xfer_seq;
   localparam int AW = 64;
   localparam int DW = 64;
   localparam int RW = 6;

   typedef struct packed {
      logic [1:0]    k;
      logic [RW-1:0] r;
      logic [AW-1:0] a;
      logic          w;
   } ent_t;

   logic clk = 1'b0, rst_n = 1'b0;
   logic start_valid = 1'b0, with_link = 1'b0, with_gp = 1'b0, with_guard = 1'b0;
   logic is_restore = 1'b0, req_ready = 1'b0;
   logic [RW-1:0] span_hi = '0, span_lo = '0;
   logic [AW-1:0] sp_in = '0;
   logic [DW-1:0] canary_cfg = 64'hC0DE_5AFE_1234_9876;
   logic [DW-1:0] guard_word = 64'hC0DE_5AFE_1234_9876;
   logic start_ready, req_valid, req_write, done, canary_fault;
   logic [AW-1:0] req_addr, sp_out;
   logic [1:0] req_kind;
   logic [RW-1:0] req_reg;
   logic [DW-1:0] mem_rdata;

   int total = 0, bad = 0;
   ent_t got [0:79];
   ent_t expv [0:79];

   always #5ns clk = ~clk;

   assign mem_rdata = (req_kind == 2'd3) ? guard_word : 64'h0;

   multi_xfer_seq dut (
      .clk(clk), .rst_n(rst_n), .start_valid(start_valid), .start_ready(start_ready),
      .span_hi(span_hi), .span_lo(span_lo), .with_link(with_link), .with_gp(with_gp),
      .with_guard(with_guard), .is_restore(is_restore), .sp_in(sp_in),
      .canary_cfg(canary_cfg), .req_valid(req_valid), .req_ready(req_ready),
      .req_addr(req_addr), .req_kind(req_kind), .req_reg(req_reg), .req_write(req_write),
      .mem_rdata(mem_rdata), .done(done), .sp_out(sp_out), .canary_fault(canary_fault));

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [AW-1:0] act, input logic [AW-1:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   // Builds the expected request list from the requirements (R2..R5, R10).
   task automatic build(input bit lnk, input bit gp, input bit grd, input bit ld,
                        input int hi, input int lo, input logic [AW-1:0] sp, output int n);
      logic [AW-1:0] s = sp;
      n = 0;
      if (!ld) begin
         if (lnk) begin s -= 8; expv[n] = '{2'd1, '0, s, 1'b1}; n++; end
         if (gp)  begin s -= 8; expv[n] = '{2'd2, '0, s, 1'b1}; n++; end
         if (hi >= lo) for (int r = lo; r <= hi; r++) begin
            s -= 8; expv[n] = '{2'd0, RW'(r), s, 1'b1}; n++;
         end
         if (grd) begin s -= 8; expv[n] = '{2'd3, '0, s, 1'b1}; n++; end
      end else begin
         if (grd) begin expv[n] = '{2'd3, '0, s, 1'b0}; n++; s += 8; end
         if (hi >= lo) for (int r = hi; r >= lo; r--) begin
            expv[n] = '{2'd0, RW'(r), s, 1'b0}; n++; s += 8;
         end
         if (gp)  begin expv[n] = '{2'd2, '0, s, 1'b0}; n++; s += 8; end
         if (lnk) begin expv[n] = '{2'd1, '0, s, 1'b0}; n++; s += 8; end
      end
   endtask

   task automatic run_op(input string name, input bit lnk, input bit gp, input bit grd,
                         input bit ld, input int hi, input int lo, input logic [AW-1:0] sp,
                         input bit stall, input bit intrude, input int exp_faults);
      int n, ng = 0, cyc = 0, faults = 0;
      bit seen_done = 0, prev_stall = 0;
      ent_t prev_e;
      logic [AW-1:0] sp_done = '0, sp_exp;
      build(lnk, gp, grd, ld, hi, lo, sp, n);
      sp_exp = ld ? sp + AW'(8 * n) : sp - AW'(8 * n);
      @(negedge clk);
      chk(start_ready === 1'b1, "R1", {name, " idle before start"}, start_ready, 1);
      with_link = lnk; with_gp = gp; with_guard = grd; is_restore = ld;
      span_hi = RW'(hi); span_lo = RW'(lo); sp_in = sp; start_valid = 1'b1;
      prev_e = '0;
      while (!seen_done && cyc < 400) begin
         @(negedge clk);
         cyc++;
         start_valid = 1'b0;
         if (intrude && cyc == 1) begin
            // R1: offer a conflicting operation while busy
            start_valid = 1'b1; is_restore = ~ld; with_link = 1'b1; with_gp = 1'b1;
            span_hi = 6'd40; span_lo = 6'd1; sp_in = 64'hDEAD_0000;
         end
         req_ready = stall ? (cyc % 3 == 0) : 1'b1;
         if (prev_stall) begin
            chk(req_valid && {req_kind, req_reg, req_addr, req_write} == prev_e, "R7",
                {name, " held under stall"}, req_addr, prev_e.a);
         end
         prev_stall = req_valid && !req_ready;
         prev_e = '{req_kind, req_reg, req_addr, req_write};
         if (req_valid && req_ready && ng < 80) begin
            got[ng] = '{req_kind, req_reg, req_addr, req_write};
            ng++;
         end
         if (canary_fault) faults++;
         if (done) begin seen_done = 1; sp_done = sp_out; end
      end
      start_valid = 1'b0;
      chk(seen_done, "R9", {name, " done seen"}, AW'(seen_done), 1);
      chk(ng == n, "R2", {name, " request count"}, AW'(ng), AW'(n));
      for (int i = 0; i < n && i < ng; i++) begin
         chk(got[i].k == expv[i].k && got[i].r == expv[i].r, ld ? "R5" : "R2",
             $sformatf("%s slot %0d kind/reg (R3 R10)", name, i),
             AW'({got[i].k, got[i].r}), AW'({expv[i].k, expv[i].r}));
         chk(got[i].a == expv[i].a && got[i].w == expv[i].w, ld ? "R5" : "R4",
             $sformatf("%s slot %0d addr", name, i), got[i].a, expv[i].a);
      end
      chk(sp_done == sp_exp, "R9", {name, " final sp"}, sp_done, sp_exp);
      if (!stall) chk(cyc == n + 1, "R9", {name, " done timing"}, AW'(cyc), AW'(n + 1));
      chk(faults == exp_faults, "R6", {name, " fault pulses"}, AW'(faults), AW'(exp_faults));
      @(negedge clk);
      chk(!done && !req_valid, "R9", {name, " done one cycle"}, AW'({done, req_valid}), 0);
      req_ready = 1'b0;
   endtask

   task automatic t_reset();
      @(negedge clk);
      chk(!req_valid, "R11", "reset req_valid", AW'(req_valid), 0);
      chk(!done, "R11", "reset done", AW'(done), 0);
      chk(!canary_fault, "R11", "reset fault", AW'(canary_fault), 0);
      chk(start_ready, "R11", "reset start_ready", AW'(start_ready), 1);
   endtask

   task automatic t_save_full();
      run_op("save_full", 1, 1, 1, 0, 5, 3, 64'h1000, 0, 1, 0);
   endtask

   task automatic t_restore_good();
      guard_word = canary_cfg;
      run_op("restore_good", 1, 1, 1, 1, 5, 3, 64'h0FC8, 0, 0, 0);
   endtask

   task automatic t_restore_bad_stall();
      guard_word = canary_cfg ^ 64'h1;
      run_op("restore_bad", 0, 1, 1, 1, 8, 7, 64'h2000, 1, 0, 1);
      guard_word = canary_cfg;
   endtask

   task automatic t_empty();
      run_op("empty_R8", 0, 0, 0, 0, 2, 5, 64'h3330, 0, 0, 0);
   endtask

   task automatic t_single_span_stall();
      run_op("single_R3", 0, 0, 0, 0, 63, 63, 64'h4000, 1, 0, 0);
   endtask

   task automatic t_no_span_restore();
      run_op("nospan_R3", 1, 0, 1, 1, 1, 9, 64'h5000, 1, 0, 0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      @(negedge clk) rst_n = 1'b1;
      t_reset();
      t_save_full();
      t_restore_good();
      t_restore_bad_stall();
      t_empty();
      t_single_span_stall();
      t_no_span_restore();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule